// File: doc/BRIEF.md
# Keypad Digit Entry Shift Register

This block sits behind a 4x4 matrix keypad whose row and column lines are read as active-low codes. Each recognised key becomes a 4-bit hexadecimal value. That value is pushed into a four-digit entry register exactly once for every physical press, so a typed sequence scrolls across a four-digit display. The newest digit always sits in the lowest nibble.

Both keypad buses first pass through a two-flop synchroniser. A press detector then waits for the same valid key to stay stable for a programmable number of cycles before it issues a single accept pulse. After that it ignores the keypad until every row has read idle for the same number of cycles. A key that is held down, or that bounces briefly on release, therefore enters one digit only.

Top module: `keypad_digit_shifter`

## Requirements
- R1: `key_active` is 0 when the synchronised row bus reads 4'b1111. It is 1 for any other row value, including invalid ones. It follows the row input two clock cycles later.
- R2: A valid key has exactly one low bit on the row bus and exactly one low bit on the column bus. Row 4'b0111 is the top row, 4'b1011 the second, 4'b1101 the third and 4'b1110 the bottom row. Column codes 4'b0111, 4'b1011, 4'b1101 and 4'b1110 run from left to right. The keys map to these values: top row 1,2,3,F; second row 4,5,6,E; third row 7,8,9,D; bottom row A,0,B,C.
- R3: An accepted key shifts `entry` left by one nibble. Bits [11:0] move to [15:4] and the key value enters [3:0]. Typing 1, 2, 3 after reset gives 16'h0123. `entry` changes at no other time.
- R4: Entering a fifth key discards the oldest digit. Typing 1, 2, 3, 4, 5 gives 16'h2345.
- R5: A key is accepted only after the same valid code has been seen on STABLE_CYCLES consecutive synchronised cycles. A press seen for STABLE_CYCLES-1 cycles is ignored. With the default of 4, this means an input held for 3 cycles is ignored and one held for 4 cycles is accepted.
- R6: After an accept, no further digit enters until the row bus has read 4'b1111 for STABLE_CYCLES consecutive cycles. A held key gives one digit. A release shorter than that window, followed by another press, gives no new digit.
- R7: A row or column pattern with more than one low bit, or a column with no low bit, is ignored and never changes `entry`.
- R8: While `rst` is high at a clock edge, `entry` is cleared to 0, the synchroniser reloads the idle code and the detector re-arms. A key held through reset is accepted once after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_n | input | 4 | Keypad row code, active low |
| col_n | input | 4 | Keypad column code, active low |
| entry | output | 16 | Four packed hex digits, newest in [3:0] |
| key_active | output | 1 | High while any row line reads low |

## Verification
The assertions check these rules on every cycle:
- `entry` moves only on an accept pulse, and then exactly by one nibble carrying the decoded value.
- An accept never comes from an invalid code or while the rows are idle.
- An accept never comes earlier than the stability window allows.
- Two accepts never occur back to back.
- Reset leaves a zero register.

Only the directed scenarios can show the parts that depend on the stimulus history:
- the full key map;
- the 1-2-3 scroll and the loss of the oldest digit;
- the exact ignore/accept boundary at STABLE_CYCLES-1 versus STABLE_CYCLES cycles;
- one digit per held key and through a short release bounce;
- acceptance of a key held through reset.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  localparam int KP_LINES = 4;
  localparam int KP_NIB   = 4;

  typedef enum logic {
    DET_ARMED = 1'b0,
    DET_HELD  = 1'b1
  } det_state_e;

  // True when exactly one line of an active-low bus is pulled low.
  function automatic logic single_low(input logic [KP_LINES-1:0] v);
    return ($countones(~v) == 1);
  endfunction

  // Hex value of a key from its row and column codes (telephone layout,
  // letters in the right column and bottom row).
  function automatic logic [KP_NIB-1:0] key_value(input logic [KP_LINES-1:0] r,
                                                  input logic [KP_LINES-1:0] c);
    logic [KP_NIB-1:0] v;
    unique case ({r, c})
      8'b0111_0111: v = 4'h1;
      8'b0111_1011: v = 4'h2;
      8'b0111_1101: v = 4'h3;
      8'b0111_1110: v = 4'hF;
      8'b1011_0111: v = 4'h4;
      8'b1011_1011: v = 4'h5;
      8'b1011_1101: v = 4'h6;
      8'b1011_1110: v = 4'hE;
      8'b1101_0111: v = 4'h7;
      8'b1101_1011: v = 4'h8;
      8'b1101_1101: v = 4'h9;
      8'b1101_1110: v = 4'hD;
      8'b1110_0111: v = 4'hA;
      8'b1110_1011: v = 4'h0;
      8'b1110_1101: v = 4'hB;
      8'b1110_1110: v = 4'hC;
      default:      v = 4'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '1;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '1;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/kpd_decode.sv
module kpd_decode
  import kpd_pkg::*;
(
  input  logic [KP_LINES-1:0] row_s,
  input  logic [KP_LINES-1:0] col_s,
  output logic                code_valid,
  output logic [KP_NIB-1:0]   code,
  output logic                rows_idle
);

  assign rows_idle  = &row_s;
  assign code_valid = single_low(row_s) && single_low(col_s);
  assign code       = key_value(row_s, col_s);

endmodule

// File: rtl/kpd_press_detect.sv
module kpd_press_detect
  import kpd_pkg::*;
#(
  parameter int STABLE_CYCLES = 4,
  localparam int CW = $clog2(STABLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_valid,
  input  logic [KP_NIB-1:0] code,
  input  logic              rows_idle,
  output logic              accept
);

  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  det_state_e        state;
  logic [CW-1:0]     cnt;
  logic [KP_NIB-1:0] cand;
  logic              same_key;

  assign same_key = code_valid && (cnt != '0) && (code == cand);
  assign accept   = (state == DET_ARMED) && same_key && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DET_ARMED;
      cnt   <= '0;
      cand  <= '0;
    end else begin
      unique case (state)
        DET_ARMED: begin
          if (!code_valid) begin
            cnt <= '0;
          end else if (accept) begin
            state <= DET_HELD;
            cnt   <= '0;
          end else if (same_key) begin
            cnt <= cnt + 1'b1;
          end else begin
            cand <= code;
            cnt  <= CW'(1);
          end
        end
        DET_HELD: begin
          if (!rows_idle) begin
            cnt <= '0;
          end else if (cnt == LAST) begin
            state <= DET_ARMED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= DET_ARMED;
      endcase
    end
  end

endmodule

// File: rtl/kpd_shift_reg.sv
module kpd_shift_reg #(
  parameter int DIGITS = 4,
  parameter int NIB    = 4,
  localparam int DW = DIGITS * NIB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [NIB-1:0] din,
  output logic [DW-1:0]  q
);

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
      if (d == 0) begin : g_low
        always_ff @(posedge clk) begin
          if (rst)       q[NIB-1:0] <= '0;
          else if (load) q[NIB-1:0] <= din;
        end
      end else begin : g_up
        always_ff @(posedge clk) begin
          if (rst)       q[d*NIB +: NIB] <= '0;
          else if (load) q[d*NIB +: NIB] <= q[(d-1)*NIB +: NIB];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/keypad_digit_shifter.sv
module keypad_digit_shifter
  import kpd_pkg::*;
#(
  parameter int STABLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int DIGITS        = 4,
  localparam int DW = DIGITS * KP_NIB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [KP_LINES-1:0] row_n,
  input  logic [KP_LINES-1:0] col_n,
  output logic [DW-1:0]       entry,
  output logic                key_active
);

  logic [KP_LINES-1:0] row_s;
  logic [KP_LINES-1:0] col_s;
  logic                code_valid;
  logic [KP_NIB-1:0]   key_code;
  logic                rows_idle;
  logic                accept_pulse;

  kpd_sync #(.W(2*KP_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({row_n, col_n}),
    .q   ({row_s, col_s})
  );

  kpd_decode u_dec (
    .row_s      (row_s),
    .col_s      (col_s),
    .code_valid (code_valid),
    .code       (key_code),
    .rows_idle  (rows_idle)
  );

  kpd_press_detect #(.STABLE_CYCLES(STABLE_CYCLES)) u_det (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code       (key_code),
    .rows_idle  (rows_idle),
    .accept     (accept_pulse)
  );

  kpd_shift_reg #(.DIGITS(DIGITS), .NIB(KP_NIB)) u_sr (
    .clk  (clk),
    .rst  (rst),
    .load (accept_pulse),
    .din  (key_code),
    .q    (entry)
  );

  assign key_active = !rows_idle;

endmodule

// File: rtl/kpd_entry_checker.sv
module kpd_entry_checker #(
  parameter int STABLE_CYCLES = 4,
  parameter int DW = 16,
  localparam int CW = $clog2(STABLE_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          code_valid,
  input logic [3:0]    code,
  input logic          key_active,
  input logic [DW-1:0] entry
);

  logic [CW-1:0] run;
  logic [3:0]    code_q;
  logic          rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q  <= rst;
    code_q <= code;
    if (rst || !code_valid)
      run <= '0;
    else if (run != '0 && code != code_q)
      run <= CW'(1);
    else if (run != CW'(STABLE_CYCLES))
      run <= run + 1'b1;
  end

  always @(posedge clk) begin
    if (rst_q) assert_reset_clear_R8: assert (entry == '0);
  end

  assert_idle_no_accept_R1: assert property (@(posedge clk) disable iff (rst)
    accept |-> key_active);
  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> entry[3:0] == $past(code));
  assert_shift_up_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> entry[DW-1:4] == $past(entry[DW-5:0]));
  assert_hold_when_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(entry));
  assert_stable_window_R5: assert property (@(posedge clk) disable iff (rst)
    accept |-> (run >= CW'(STABLE_CYCLES - 1)) && (code == code_q));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);
  assert_valid_only_R7: assert property (@(posedge clk) disable iff (rst)
    accept |-> code_valid);

endmodule

bind keypad_digit_shifter kpd_entry_checker #(
  .STABLE_CYCLES (STABLE_CYCLES),
  .DW            (DW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .accept     (accept_pulse),
  .code_valid (code_valid),
  .code       (key_code),
  .key_active (key_active),
  .entry      (entry)
);

// File: tb/sim_keypad_digit_shifter.sv
`timescale 1ns/1ps
module sim_keypad_digit_shifter;

  localparam int N    = 4;
  localparam int HOLD = N + 8;
  localparam int REL  = N + 8;
  // Telephone layout, row-major from top-left, one nibble per key.
  localparam logic [63:0] KMAP = 64'h123F_456E_789D_A0BC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  row_n = 4'hF;
  logic [3:0]  col_n = 4'hF;
  logic [15:0] entry;
  logic        key_active;
  logic [15:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keypad_digit_shifter #(.STABLE_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n),
    .entry(entry), .key_active(key_active)
  );

  function automatic logic [3:0] line_code(input int i);
    return ~(4'b1000 >> i);
  endfunction

  function automatic logic [3:0] map_val(input int r, input int c);
    return KMAP[63 - 4*(r*4 + c) -: 4];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] r, input logic [3:0] c, input int cyc);
    row_n = r; col_n = c;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic press_key(input int r, input int c);
    drive(line_code(r), line_code(c), HOLD);
    drive(4'hF, 4'hF, REL);
    model = {model[11:0], map_val(r, c)};
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = '0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R8 entry after reset", 32'(entry), 32'h0);
    chk("R1 idle after reset", 32'(key_active), 32'h0);
  endtask

  task automatic t_active_flag();
    row_n = 4'b1011; col_n = 4'hF;
    @(negedge clk);
    chk("R1 not yet through sync", 32'(key_active), 32'h0);
    @(negedge clk);
    chk("R1 active two cycles later", 32'(key_active), 32'h1);
    drive(4'b0011, 4'hF, 3);
    chk("R1 active on invalid row", 32'(key_active), 32'h1);
    drive(4'hF, 4'hF, REL);
    chk("R1 idle again", 32'(key_active), 32'h0);
    chk("R7 column-less press ignored", 32'(entry), 32'(model));
  endtask

  task automatic t_sequence();
    do_reset();
    press_key(0, 0);
    chk("R3 first digit", 32'(entry), 32'h0001);
    press_key(0, 1);
    chk("R3 second digit", 32'(entry), 32'h0012);
    press_key(0, 2);
    chk("R3 1-2-3 scroll", 32'(entry), 32'h0123);
  endtask

  task automatic t_overflow();
    press_key(1, 0);
    press_key(1, 1);
    chk("R4 fifth key drops oldest", 32'(entry), 32'h2345);
  endtask

  task automatic t_keymap();
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        press_key(r, c);
        chk($sformatf("R2 key row %0d col %0d", r, c), 32'(entry), 32'(model));
      end
    end
  endtask

  task automatic t_window();
    drive(line_code(2), line_code(2), N - 1);
    drive(4'hF, 4'hF, REL);
    chk("R5 press of N-1 cycles ignored", 32'(entry), 32'(model));
    drive(line_code(2), line_code(2), N);
    drive(4'hF, 4'hF, REL);
    model = {model[11:0], 4'h9};
    chk("R5 press of N cycles accepted", 32'(entry), 32'(model));
  endtask

  task automatic t_held_bounce();
    drive(line_code(3), line_code(1), 6 * HOLD);
    chk("R6 long hold one digit", 32'(entry), 32'({model[11:0], 4'h0}));
    model = {model[11:0], 4'h0};
    drive(4'hF, 4'hF, N - 1);
    drive(line_code(3), line_code(1), HOLD);
    drive(4'hF, 4'hF, REL);
    chk("R6 short release bounce no digit", 32'(entry), 32'(model));
  endtask

  task automatic t_invalid();
    drive(4'b0101, line_code(0), HOLD);
    drive(4'hF, 4'hF, REL);
    chk("R7 two rows low ignored", 32'(entry), 32'(model));
    drive(line_code(1), 4'b1001, HOLD);
    drive(4'hF, 4'hF, REL);
    chk("R7 two columns low ignored", 32'(entry), 32'(model));
  endtask

  task automatic t_reset_rearm();
    press_key(0, 3);
    row_n = line_code(1); col_n = line_code(2);
    repeat (HOLD) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 cleared with key held", 32'(entry), 32'h0);
    rst = 1'b0;
    repeat (HOLD) @(negedge clk);
    chk("R8 re-armed accepts held key", 32'(entry), 32'h0006);
    drive(4'hF, 4'hF, REL);
    model = 16'h0006;
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_active_flag();
    t_sequence();
    t_overflow();
    t_keymap();
    t_window();
    t_held_bounce();
    t_invalid();
    t_reset_rearm();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule